// File: doc/BRIEF.md
# Waveform Timer Channel

This block is one channel of a general-purpose timer. It counts up on a chosen timing source: the system clock through a fixed prescaler, a slow-clock strobe, or an external input synchronised into the clock domain. The counter can run freely across its whole range. It can also compare against a limit register and return to zero there, which gives a periodic tick. A stop option halts the channel on that match instead, so one programmed delay fires once.

A second compare register and the limit register together drive a waveform output. Each match can set, clear or toggle that output. With the first compare at zero and the limit at half range, the output is a square wave with a 50 % duty cycle. Software talks to the channel through a small synchronous register port. It uses one-shot command writes to start, stop or restart the count, a sticky match flag, and an interrupt mask that has separate set and clear addresses.

Top module: `wave_timer_chan`

## Requirements
- R1: After a synchronous reset the count is 0, the channel is stopped, wave_a is 0, the interrupt mask is 0, the match flag is 0 and irq is 0.
- R2: Source select CTRL[2:0] (address 0): values 0, 1, 2 and 3 give one count step per 2, 8, 32 and 128 clocks, taken on cycles where the low 1, 3, 5 or 7 bits of a prescaler that runs freely from reset are all ones. Value 4 steps on every clock with slow_en high. Value 5 steps once per rising edge of ext_in after a two-flop synchroniser. Values 6 and 7 never step.
- R3: With CTRL[3]=0 (free-run) the count steps from all ones to 0, and a match on the limit does not reload it.
- R4: With CTRL[3]=1 (auto-restart) a step taken while the count equals the limit register RC (address 4) loads 0, so one period is RC+1 steps.
- R5: A limit match is a step taken while the count equals RC, in any mode. It sets STATUS[0] (address 5). The flag stays set until STATUS is read. A read returns the flag and clears it, unless a new match occurs in the same cycle.
- R6: With CTRL[4]=1 a limit match also stops the channel. The count then holds the value loaded by that step.
- R7: A write to CMD (address 1) acts on three bits. Bit 0 starts the channel and bit 1 stops it; stop wins when both are set. Bit 2 loads 0 into the count on the next cycle, and no step is taken in that cycle. STATUS[1] reads 1 while the channel runs.
- R8: While the channel is stopped the count does not change.
- R9: Writing 1 to bit 0 of address 6 sets the mask bit, and writing 1 to bit 0 of address 7 clears it (so writing all ones clears it). The mask reads back at address 8. irq is the match flag ANDed with the mask.
- R10: The wave_a action for an RA (address 3) match is set by CTRL[6:5], and the action for a limit match by CTRL[8:7]. The encodings are 0 hold, 1 set, 2 clear, 3 toggle. An RA match is a step taken while the count equals RA. When both matches occur on one step, the limit action wins.
- R11: Read data appears on rdata the cycle after rd_en and holds until the next read. Write-only addresses read as 0. The count register (address 2) is read-only, and writes to it are ignored.
- R12: In free-run mode with RA=0, RC=0x8000, set on RA and clear on the limit, and a step every cycle, wave_a is high for exactly half of the 16-bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (4) | Register address |
| wdata | input | CNT_W (16) | Write data |
| rdata | output | CNT_W (16) | Registered read data |
| slow_en | input | 1 | Slow-clock step strobe |
| ext_in | input | 1 | Asynchronous external count input |
| wave_a | output | 1 | Waveform output A |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase or a wrong source select shows as a count read back a few steps off. A wrong limit comparison shows as a flag, irq or wave_a edge in the wrong clock cycle. The bench runs a cycle-accurate reference model beside the design and compares rdata, wave_a and irq on every cycle, so a bad internal state is caught one cycle after it first reaches a port, or at the next read of the count. Directed cases with hand-computed values cover one-shot stopping, command priority, synchronised edge counting and the half-period duty measurement.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TOG  = 2'd3
  } act_e;

  // Control register layout, LSB first: source, auto-restart, stop, A action, C action
  typedef struct packed {
    act_e       act_c;
    act_e       act_a;
    logic       stop_c;
    logic       auto_rst;
    logic [2:0] clk_sel;
  } ctrl_t;

  localparam int CTRL_W  = $bits(ctrl_t);
  localparam int NUM_DIV = 4;

  localparam int A_CTRL = 0;
  localparam int A_CMD  = 1;
  localparam int A_CNT  = 2;
  localparam int A_RA   = 3;
  localparam int A_RC   = 4;
  localparam int A_STAT = 5;
  localparam int A_IER  = 6;
  localparam int A_IDR  = 7;
  localparam int A_IMR  = 8;

  function automatic logic apply_act(input act_e a, input logic cur);
    case (a)
      ACT_SET: apply_act = 1'b1;
      ACT_CLR: apply_act = 1'b0;
      ACT_TOG: apply_act = ~cur;
      default: apply_act = cur;
    endcase
  endfunction

endpackage

// File: rtl/wtc_tick_gen.sv
module wtc_tick_gen
  import wtc_pkg::*;
#(
  parameter int N_DIV       = NUM_DIV,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       slow_en,
  input  logic       ext_in,
  output logic       tick
);
  localparam int PRE_W  = 2 * N_DIV - 1;
  localparam int DIV_IW = $clog2(N_DIV);
  localparam logic [2:0] SEL_SLOW = 3'(N_DIV);
  localparam logic [2:0] SEL_EXT  = 3'(N_DIV + 1);

  logic [PRE_W-1:0]       pre_q;
  logic [N_DIV-1:0]       div_tick;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev_q;
  logic                   ext_tick;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  // Divider taps: divide by 2^(2g+1)
  for (genvar g = 0; g < N_DIV; g++) begin : g_tap
    assign div_tick[g] = &pre_q[2*g:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q     <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], ext_in};
      ext_prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign ext_tick = sync_q[SYNC_STAGES-1] & ~ext_prev_q;

  always_comb begin
    tick = 1'b0;
    if (int'(sel) < N_DIV)  tick = div_tick[sel[DIV_IW-1:0]];
    else if (sel == SEL_SLOW) tick = slow_en;
    else if (sel == SEL_EXT)  tick = ext_tick;
  end

  // R2: divide-by-2 source never steps on two cycles in a row
  assert_div2_alternate_R2: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd0 && tick) |=> !(sel == 3'd0 && tick));

  // R2: an external edge step is always followed by a cycle without one
  assert_ext_single_R2: assert property (@(posedge clk) disable iff (rst)
    ext_tick |=> !ext_tick);

endmodule

// File: rtl/wtc_count_core.sv
module wtc_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         auto_rst,
  input  logic         stop_c,
  input  logic [W-1:0] ra,
  input  logic [W-1:0] rc,
  input  logic         cmd_en,
  input  logic         cmd_dis,
  input  logic         cmd_trg,
  output logic [W-1:0] cnt,
  output logic         run,
  output logic         ev_a,
  output logic         ev_c
);
  logic [W-1:0] cnt_q;
  logic         run_q;
  logic         step;

  assign step = run_q & tick & ~cmd_trg;
  assign ev_a = step && (cnt_q == ra);
  assign ev_c = step && (cnt_q == rc);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cmd_trg) begin
      cnt_q <= '0;
    end else if (step) begin
      if (auto_rst && cnt_q == rc) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  run_q <= 1'b0;
    else if (cmd_dis)         run_q <= 1'b0;
    else if (cmd_en)          run_q <= 1'b1;
    else if (ev_c && stop_c)  run_q <= 1'b0;
  end

  assign cnt = cnt_q;
  assign run = run_q;

  assert_trigger_zero_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_trg |=> cnt_q == '0);

  assert_disable_wins_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_dis |=> !run_q);

  assert_stopped_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !cmd_trg) |=> cnt_q == $past(cnt_q));

  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_c && stop_c && !cmd_en) |=> !run_q);

  assert_auto_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_c && auto_rst) |=> cnt_q == '0);

endmodule

// File: rtl/wtc_wave_out.sv
module wtc_wave_out
  import wtc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ev_a,
  input  logic ev_c,
  input  act_e act_a,
  input  act_e act_c,
  output logic wave
);
  logic wave_q;

  always_ff @(posedge clk) begin
    if (rst)       wave_q <= 1'b0;
    else if (ev_c) wave_q <= apply_act(act_c, wave_q);
    else if (ev_a) wave_q <= apply_act(act_a, wave_q);
  end

  assign wave = wave_q;

  assert_c_set_R10: assert property (@(posedge clk) disable iff (rst)
    (ev_c && act_c == ACT_SET) |=> wave_q);

  assert_c_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (ev_c && act_c == ACT_CLR) |=> !wave_q);

  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!ev_a && !ev_c) |=> $stable(wave_q));

endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
  import wtc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              slow_en,
  input  logic              ext_in,
  output logic              wave_a,
  output logic              irq
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] ra_q, rc_q, cnt, rdata_q;
  logic             flag_q, mask_q, run, ev_a, ev_c, tick;
  logic             wr_cmd, wr_ier, wr_idr, rd_stat;
  logic             cmd_en, cmd_dis, cmd_trg;

  assign wr_cmd  = wr_en && addr == ADDR_W'(A_CMD);
  assign wr_ier  = wr_en && addr == ADDR_W'(A_IER);
  assign wr_idr  = wr_en && addr == ADDR_W'(A_IDR);
  assign rd_stat = rd_en && addr == ADDR_W'(A_STAT);
  assign cmd_en  = wr_cmd & wdata[0];
  assign cmd_dis = wr_cmd & wdata[1];
  assign cmd_trg = wr_cmd & wdata[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= ctrl_t'('0);
      ra_q   <= '0;
      rc_q   <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_CTRL)) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (addr == ADDR_W'(A_RA))   ra_q   <= wdata;
      if (addr == ADDR_W'(A_RC))   rc_q   <= wdata;
    end
  end

  wtc_tick_gen #(.N_DIV(NUM_DIV), .SYNC_STAGES(2)) u_tick (
    .clk(clk), .rst(rst), .sel(ctrl_q.clk_sel),
    .slow_en(slow_en), .ext_in(ext_in), .tick(tick)
  );

  wtc_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick),
    .auto_rst(ctrl_q.auto_rst), .stop_c(ctrl_q.stop_c),
    .ra(ra_q), .rc(rc_q),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_trg(cmd_trg),
    .cnt(cnt), .run(run), .ev_a(ev_a), .ev_c(ev_c)
  );

  wtc_wave_out u_wave (
    .clk(clk), .rst(rst), .ev_a(ev_a), .ev_c(ev_c),
    .act_a(ctrl_q.act_a), .act_c(ctrl_q.act_c), .wave(wave_a)
  );

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (ev_c)    flag_q <= 1'b1;
    else if (rd_stat) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                      mask_q <= 1'b0;
    else if (wr_ier && wdata[0])  mask_q <= 1'b1;
    else if (wr_idr && wdata[0])  mask_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (addr)
        ADDR_W'(A_CTRL): rdata_q <= CNT_W'(ctrl_q);
        ADDR_W'(A_CNT):  rdata_q <= cnt;
        ADDR_W'(A_RA):   rdata_q <= ra_q;
        ADDR_W'(A_RC):   rdata_q <= rc_q;
        ADDR_W'(A_STAT): rdata_q <= CNT_W'({run, flag_q});
        ADDR_W'(A_IMR):  rdata_q <= CNT_W'(mask_q);
        default:         rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;
  assign irq   = flag_q & mask_q;

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !rd_stat) |=> flag_q);

  assert_match_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
    ev_c |=> flag_q);

  assert_disable_masks_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_idr && wdata[0]) |=> !irq);

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));

endmodule

// File: tb/wave_timer_chan_tb_top.sv
module wave_timer_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        slow_en = 1'b0, ext_in = 1'b0;
  logic        wave_a, irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  wave_timer_chan dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .slow_en(slow_en), .ext_in(ext_in),
    .wave_a(wave_a), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // ---------------- reference model built from the requirements ----------------
  logic [6:0]  m_pre;
  logic        m_s1, m_s2, m_s3;
  logic [15:0] m_cnt, m_ra, m_rc, m_rdata;
  logic [8:0]  m_ctrl;
  logic        m_run, m_flag, m_mask, m_wave;

  function automatic logic [6:0] dmask(input int i);
    return 7'((1 << (2 * i + 1)) - 1);
  endfunction

  function automatic logic act(input logic [1:0] a, input logic cur);
    case (a)
      2'd1: return 1'b1;
      2'd2: return 1'b0;
      2'd3: return ~cur;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk) begin
    logic tk, wc, en, dis, trg, step, eva, evc;
    logic [15:0] rv;
    if (rst) begin
      m_pre = '0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_cnt = '0; m_ra = '0; m_rc = '0; m_rdata = '0; m_ctrl = '0;
      m_run = 0; m_flag = 0; m_mask = 0; m_wave = 0;
    end else begin
      if (m_ctrl[2:0] < 3'd4)       tk = (m_pre & dmask(int'(m_ctrl[1:0]))) == dmask(int'(m_ctrl[1:0]));
      else if (m_ctrl[2:0] == 3'd4) tk = slow_en;
      else if (m_ctrl[2:0] == 3'd5) tk = m_s2 & ~m_s3;
      else                          tk = 1'b0;
      wc   = wr_en && addr == 4'd1;
      en   = wc & wdata[0];
      dis  = wc & wdata[1];
      trg  = wc & wdata[2];
      step = m_run && tk && !trg;
      eva  = step && m_cnt == m_ra;
      evc  = step && m_cnt == m_rc;
      case (addr)
        4'd0: rv = {7'd0, m_ctrl};
        4'd2: rv = m_cnt;
        4'd3: rv = m_ra;
        4'd4: rv = m_rc;
        4'd5: rv = {14'd0, m_run, m_flag};
        4'd8: rv = {15'd0, m_mask};
        default: rv = '0;
      endcase
      if (rd_en) m_rdata = rv;
      if (evc) m_flag = 1'b1;
      else if (rd_en && addr == 4'd5) m_flag = 1'b0;
      if (evc)      m_wave = act(m_ctrl[8:7], m_wave);
      else if (eva) m_wave = act(m_ctrl[6:5], m_wave);
      if (trg) m_cnt = '0;
      else if (step) m_cnt = (m_ctrl[3] && m_cnt == m_rc) ? 16'd0 : m_cnt + 16'd1;
      if (dis) m_run = 1'b0;
      else if (en) m_run = 1'b1;
      else if (evc && m_ctrl[4]) m_run = 1'b0;
      if (wr_en && addr == 4'd6 && wdata[0]) m_mask = 1'b1;
      else if (wr_en && addr == 4'd7 && wdata[0]) m_mask = 1'b0;
      if (wr_en && addr == 4'd0) m_ctrl = wdata[8:0];
      if (wr_en && addr == 4'd3) m_ra = wdata;
      if (wr_en && addr == 4'd4) m_rc = wdata;
      m_pre = m_pre + 7'd1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
    end
  end

  // Lockstep comparison a quarter period after each edge
  always @(posedge clk) begin
    #5;
    chk("R11 lockstep rdata", rdata, m_rdata);
    chk("R10 lockstep wave_a", wave_a, m_wave);
    chk("R9 lockstep irq", irq, m_flag & m_mask);
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = 4'(a);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int highs;
    void'($urandom(32'h5eed_1234));
    idle(3);
    rst = 1'b0;

    // R1: reset state
    rd(2, v); chk("R1 count after reset", v, 0);
    rd(5, v); chk("R1 status after reset", v, 0);
    rd(8, v); chk("R1 mask after reset", v, 0);
    rd(0, v); chk("R1 ctrl after reset", v, 0);
    chk("R1 wave_a after reset", wave_a, 0);
    chk("R1 irq after reset", irq, 0);

    // R11: count register ignores writes
    wr(2, 16'h1234);
    rd(2, v); chk("R11 count write ignored", v, 0);
    rd(1, v); chk("R11 write-only reads zero", v, 0);

    // R2/R3/R7: slow source, start with restart
    wr(0, 16'h0004);
    wr(1, 16'h0005);
    slow_en = 1'b1; idle(10); slow_en = 1'b0;
    rd(2, v); chk("R2 slow source steps", v, 10);
    rd(5, v); chk("R5 R7 flag and running", v, 16'h3);
    rd(5, v); chk("R5 flag cleared by read", v, 16'h2);
    wr(1, 16'h0003);
    rd(5, v); chk("R7 disable wins over enable", v, 0);
    slow_en = 1'b1; idle(5); slow_en = 1'b0;
    rd(2, v); chk("R8 stopped count holds", v, 10);
    wr(1, 16'h0004);
    rd(2, v); chk("R7 trigger clears count", v, 0);
    rd(5, v); chk("R7 trigger alone keeps stopped", v, 0);

    // R6/R9: one-shot with auto-restart and stop
    wr(0, 16'h001C);
    wr(4, 16'd3);
    wr(6, 16'h0001);
    wr(1, 16'h0005);
    slow_en = 1'b1; idle(10); slow_en = 1'b0;
    rd(2, v); chk("R6 one-shot stops at zero", v, 0);
    chk("R9 irq raised when masked in", irq, 1);
    rd(5, v); chk("R6 stopped with flag", v, 16'h1);
    chk("R9 irq drops after status read", irq, 0);
    rd(8, v); chk("R9 mask reads back", v, 1);

    // R4: periodic restart, period RC+1
    wr(0, 16'h000C);
    wr(1, 16'h0005);
    slow_en = 1'b1; idle(9); slow_en = 1'b0;
    rd(2, v); chk("R4 auto-restart period", v, 1);
    wr(1, 16'h0002);
    chk("R9 irq with mask set", irq, 1);
    wr(7, 16'hFFFF);
    chk("R9 disable all masks irq", irq, 0);
    rd(8, v); chk("R9 mask cleared", v, 0);
    rd(5, v);

    // R2: external input edges through synchroniser
    wr(0, 16'h0005);
    wr(1, 16'h0005);
    for (int i = 0; i < 5; i++) begin
      ext_in = 1'b1; idle(4); ext_in = 1'b0; idle(4);
    end
    idle(4);
    rd(2, v); chk("R2 external edges counted", v, 5);
    wr(1, 16'h0002);

    // R10: set on RA, clear on RC
    wr(0, 16'h0124);
    wr(3, 16'd2);
    wr(4, 16'd5);
    wr(1, 16'h0005);
    slow_en = 1'b1; idle(3);
    chk("R10 set on RA match", wave_a, 1);
    idle(3);
    chk("R10 clear on RC match", wave_a, 0);
    slow_en = 1'b0;
    wr(1, 16'h0002);

    // R3/R12: free-run 50% duty over a full 16-bit period
    wr(3, 16'h0000);
    wr(4, 16'h8000);
    wr(1, 16'h0005);
    slow_en = 1'b1;
    idle(16);
    highs = 0;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (wave_a) highs++;
    end
    chk("R12 half-period duty", highs, 32768);
    chk("R3 free-run wraps through RC", wave_a, m_wave);
    slow_en = 1'b0;
    wr(1, 16'h0002);

    // Constrained random phase, checked in lockstep by the model
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      slow_en = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 5) == 0) ext_in = ~ext_in;
      if (op < 4) begin
        idle(1);
      end else if (op < 7) begin
        int a;
        logic [15:0] d;
        a = int'($urandom_range(0, 8));
        case (a)
          3, 4:    d = 16'($urandom_range(0, 31));
          1:       d = 16'($urandom_range(0, 7));
          default: d = 16'($urandom_range(0, 511));
        endcase
        wr(a, d);
      end else begin
        rd(int'($urandom_range(0, 8)), v);
      end
    end
    idle(4);
    finish_run();
  end

endmodule